// File: doc/BRIEF.md
# Programmable Bit Pattern Generator

This block replays a stored sequence of elements on a small group of output pins, stepping to the next element at a programmable rate. A small pattern memory is filled through a write port that takes an address and a four-bit value. When `start` is sampled high while the generator is at rest, it captures its settings and waits for a programmable start offset. It then plays the stored elements a programmable number of times, inserting a programmable quiet interval between plays. After the final play it raises a one-cycle `done` pulse and returns to rest.

There are two output modes. In single-pin mode only bit 0 of each element appears, on pin 0, and the other three pins sit at the idle level. In hex mode the whole four-bit element is driven onto the four pins at once. Whenever no element is being played (during rest, the start offset and the gaps), every pin carries the configured idle level. Every count setting uses a minus-one encoding except the offset and the gap, which use plain cycle counts.

The controller is a four-state machine. REST waits for `start`. It goes to LEAD when the offset is non-zero, or straight to EMIT when the offset is zero. LEAD counts down the offset and then goes to EMIT. EMIT holds each element for one step period and advances the index. After the last element it goes back to REST when that was the final play. Otherwise it goes to PAUSE when the gap is non-zero, or restarts EMIT at index 0 when the gap is zero. PAUSE counts down the gap and then re-enters EMIT at index 0.

Top module: `bitseq_player`

## Requirements
- R1: After reset, `done` is low, the machine is at rest, and all four pins follow `cfg_idle`.
- R2: Pins stay at the idle level for exactly `cfg_wait` cycles after the clock edge that samples `start`. A zero offset starts the first element in the very next cycle.
- R3: Elements play from address 0 upward. There are `cfg_len`+1 of them per play, and each is held for exactly `cfg_step`+1 cycles.
- R4: In single-pin mode (`cfg_hex`=0), pin 0 carries bit 0 of the current element and pins 3..1 hold the idle level.
- R5: In hex mode (`cfg_hex`=1), bit i of the current element drives pin i for i = 0..3.
- R6: The pattern is played `cfg_reps`+1 times. Exactly `cfg_gap` idle cycles separate consecutive plays, and there is no gap after the final play.
- R7: `done` is high for exactly one cycle, the cycle after the last element of the final play ends. In that cycle the pins are back at the idle level.
- R8: A `start` pulse while a sequence is in progress has no effect on the outputs.
- R9: Settings are captured at the accepted `start`. Changing any setting other than `cfg_idle` during a sequence has no effect on that sequence.
- R10: A write with `wr_en` high stores `wr_data` at `wr_addr`, and that value is what plays at element position `wr_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Pattern write strobe |
| wr_addr | input | AW = clog2(DEPTH) | Pattern write address |
| wr_data | input | 4 | Element value to store |
| cfg_hex | input | 1 | 1: hex mode on four pins; 0: single-pin mode |
| cfg_idle | input | 1 | Idle level for all pins |
| cfg_len | input | AW | Element count minus one |
| cfg_step | input | CW | Step period minus one, in cycles |
| cfg_wait | input | CW | Start offset, in cycles |
| cfg_gap | input | CW | Gap between plays, in cycles |
| cfg_reps | input | RW | Play count minus one |
| start | input | 1 | Arms the generator when at rest |
| pins | output | 4 | Pattern outputs |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its defaults: DEPTH=16, CW=8 and RW=4. With these values a full-depth play of all sixteen addresses, the largest encoded length, is within reach, and so are multi-play runs with and without gaps. Random settings are kept small so that many complete sequences fit in a short run. Every cycle of each sequence is compared against a bench timeline function, including the offset-zero and gap-zero boundaries.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
    localparam int PINS = 4;

    typedef enum logic [1:0] {
        ST_REST  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_EMIT  = 2'd2,
        ST_PAUSE = 2'd3
    } seq_state_e;
endpackage

// File: rtl/bsp_store.sv
module bsp_store #(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH),
    parameter int DW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (wr_en && wr_addr == AW'(i)) mem[i] <= wr_data;
            end
        end
    end

    assign rd_data = mem[rd_addr];

    // R10: a write is visible at its address on the next cycle
    p_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/bsp_ctrl.sv
module bsp_ctrl
    import bsp_pkg::*;
#(
    parameter int AW = 4,
    parameter int CW = 8,
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          cfg_hex,
    input  logic          cfg_idle,
    input  logic [AW-1:0] cfg_len,
    input  logic [CW-1:0] cfg_step,
    input  logic [CW-1:0] cfg_wait,
    input  logic [CW-1:0] cfg_gap,
    input  logic [RW-1:0] cfg_reps,
    output logic [AW-1:0] rd_idx,
    output logic          playing,
    output logic          running,
    output logic          hex_q,
    output logic          idle_q,
    output logic          done
);
    localparam logic [CW-1:0] C_ONE = CW'(1);
    localparam logic [AW-1:0] A_ONE = AW'(1);
    localparam logic [RW-1:0] R_ONE = RW'(1);

    seq_state_e    state, state_nx;
    logic [CW-1:0] tmr;
    logic [AW-1:0] idx;
    logic [RW-1:0] rep;
    logic [AW-1:0] len_q;
    logic [CW-1:0] step_q;
    logic [CW-1:0] gap_q;
    logic [RW-1:0] reps_q;
    logic          tmr_zero, last_el, last_rep, finish;

    assign tmr_zero = (tmr == '0);
    assign last_el  = (idx == len_q);
    assign last_rep = (rep == reps_q);
    assign finish   = (state == ST_EMIT) && tmr_zero && last_el && last_rep;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_REST;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_REST: begin
                if (start) state_nx = (cfg_wait == '0) ? ST_EMIT : ST_LEAD;
            end
            ST_LEAD: begin
                if (tmr_zero) state_nx = ST_EMIT;
            end
            ST_EMIT: begin
                if (tmr_zero && last_el) begin
                    if (last_rep)           state_nx = ST_REST;
                    else if (gap_q == '0)   state_nx = ST_EMIT;
                    else                    state_nx = ST_PAUSE;
                end
            end
            ST_PAUSE: begin
                if (tmr_zero) state_nx = ST_EMIT;
            end
            default: state_nx = ST_REST;
        endcase
    end

    // counters and captured settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr    <= '0;
            idx    <= '0;
            rep    <= '0;
            len_q  <= '0;
            step_q <= '0;
            gap_q  <= '0;
            reps_q <= '0;
            hex_q  <= 1'b0;
            idle_q <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= finish;
            unique case (state)
                ST_REST: begin
                    if (start) begin
                        len_q  <= cfg_len;
                        step_q <= cfg_step;
                        gap_q  <= cfg_gap;
                        reps_q <= cfg_reps;
                        hex_q  <= cfg_hex;
                        idle_q <= cfg_idle;
                        idx    <= '0;
                        rep    <= '0;
                        tmr    <= (cfg_wait == '0) ? cfg_step : cfg_wait - C_ONE;
                    end
                end
                ST_LEAD: begin
                    tmr <= tmr_zero ? step_q : tmr - C_ONE;
                end
                ST_EMIT: begin
                    if (!tmr_zero) begin
                        tmr <= tmr - C_ONE;
                    end else if (!last_el) begin
                        idx <= idx + A_ONE;
                        tmr <= step_q;
                    end else if (!last_rep) begin
                        idx <= '0;
                        rep <= rep + R_ONE;
                        tmr <= (gap_q == '0) ? step_q : gap_q - C_ONE;
                    end
                end
                ST_PAUSE: begin
                    tmr <= tmr_zero ? step_q : tmr - C_ONE;
                end
                default: tmr <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        playing = (state == ST_EMIT);
        running = (state != ST_REST);
        rd_idx  = idx;
    end

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_after_emit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(state) == ST_EMIT && state == ST_REST));
    p_idx_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMIT) |-> (idx <= len_q));
    p_step_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMIT && !tmr_zero) |=> (state == ST_EMIT && $stable(idx)));
    p_lead_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LEAD && tmr_zero) |=> (state == ST_EMIT && idx == '0));
    p_pause_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAUSE && tmr_zero) |=> (state == ST_EMIT && idx == '0));
    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_REST) |=> ($stable(len_q) && $stable(step_q) && $stable(reps_q)
                                && $stable(gap_q) && $stable(hex_q)));
endmodule

// File: rtl/bsp_drive.sv
module bsp_drive #(
    parameter int PINS = 4
) (
    input  logic            playing,
    input  logic            running,
    input  logic            hex_q,
    input  logic            idle_q,
    input  logic            idle_live,
    input  logic [PINS-1:0] elem,
    output logic [PINS-1:0] pins
);
    logic lvl;
    assign lvl = running ? idle_q : idle_live;

    generate
        for (genvar g = 0; g < PINS; g++) begin : g_pin
            if (g == 0) begin : g_lead
                assign pins[g] = playing ? elem[g] : lvl;
            end else begin : g_rest
                assign pins[g] = (playing && hex_q) ? elem[g] : lvl;
            end
        end
    endgenerate

    // R4: single-pin mode keeps upper pins at the captured idle level
    always_comb begin
        if (playing && !hex_q) a_upper_idle_r4: assert (pins[PINS-1:1] == {(PINS-1){idle_q}});
    end
endmodule

// File: rtl/bitseq_player.sv
module bitseq_player
    import bsp_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = 8,
    parameter int RW    = 4,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [3:0]    wr_data,
    input  logic          cfg_hex,
    input  logic          cfg_idle,
    input  logic [AW-1:0] cfg_len,
    input  logic [CW-1:0] cfg_step,
    input  logic [CW-1:0] cfg_wait,
    input  logic [CW-1:0] cfg_gap,
    input  logic [RW-1:0] cfg_reps,
    input  logic          start,
    output logic [3:0]    pins,
    output logic          done
);
    logic [AW-1:0]   rd_idx;
    logic [PINS-1:0] elem;
    logic            playing, running, hex_q, idle_q;

    bsp_store #(.DEPTH(DEPTH), .AW(AW), .DW(PINS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_idx),
        .rd_data (elem)
    );

    bsp_ctrl #(.AW(AW), .CW(CW), .RW(RW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cfg_hex  (cfg_hex),
        .cfg_idle (cfg_idle),
        .cfg_len  (cfg_len),
        .cfg_step (cfg_step),
        .cfg_wait (cfg_wait),
        .cfg_gap  (cfg_gap),
        .cfg_reps (cfg_reps),
        .rd_idx   (rd_idx),
        .playing  (playing),
        .running  (running),
        .hex_q    (hex_q),
        .idle_q   (idle_q),
        .done     (done)
    );

    bsp_drive #(.PINS(PINS)) u_drive (
        .playing   (playing),
        .running   (running),
        .hex_q     (hex_q),
        .idle_q    (idle_q),
        .idle_live (cfg_idle),
        .elem      (elem),
        .pins      (pins)
    );

    // R1: no completion pulse while at rest without a prior sequence end
    p_done_needs_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !$past(running)) |-> !done);
endmodule

// File: tb/test_bitseq_player.sv
module test_bitseq_player;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;
    localparam int AW = 4;
    localparam int CW = 8;
    localparam int RW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [3:0]    wr_data = '0;
    logic          cfg_hex = 1'b0;
    logic          cfg_idle = 1'b1;
    logic [AW-1:0] cfg_len = '0;
    logic [CW-1:0] cfg_step = '0;
    logic [CW-1:0] cfg_wait = '0;
    logic [CW-1:0] cfg_gap = '0;
    logic [RW-1:0] cfg_reps = '0;
    logic          start = 1'b0;
    logic [3:0]    pins;
    logic          done;

    int checks = 0;
    int errors = 0;

    logic [3:0] pat [DEPTH];
    int e_len, e_step, e_wait, e_gap, e_reps;
    logic e_hex, e_idle;

    bitseq_player #(.DEPTH(DEPTH), .CW(CW), .RW(RW)) i_bitseq_player (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cfg_hex(cfg_hex), .cfg_idle(cfg_idle), .cfg_len(cfg_len), .cfg_step(cfg_step),
        .cfg_wait(cfg_wait), .cfg_gap(cfg_gap), .cfg_reps(cfg_reps), .start(start),
        .pins(pins), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // expected pin values at cycle t after the edge that accepts start
    function automatic logic [3:0] exp_pins(int t);
        int n, h, body, tt;
        logic [3:0] el;
        n = e_len + 1;
        h = e_step + 1;
        body = n * h;
        tt = t;
        if (tt < e_wait) return {4{e_idle}};
        tt -= e_wait;
        for (int r = 0; r <= e_reps; r++) begin
            if (tt < body) begin
                el = pat[tt / h];
                return e_hex ? el : {{3{e_idle}}, el[0]};
            end
            tt -= body;
            if (r < e_reps) begin
                if (tt < e_gap) return {4{e_idle}};
                tt -= e_gap;
            end
        end
        return {4{e_idle}};
    endfunction

    function automatic int end_time();
        return e_wait + (e_reps + 1) * (e_len + 1) * (e_step + 1) + e_reps * e_gap;
    endfunction

    task automatic load_pattern(input bit rnd);
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            pat[i] = rnd ? 4'($urandom) : 4'(i ^ 5);
            wr_en = 1'b1;
            wr_addr = AW'(i);
            wr_data = pat[i];
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_case(input string tag, input bit hx, input bit idl, input int ln,
                            input int st, input int wt, input int gp, input int rp,
                            input bit poke_start, input bit poke_cfg);
        int tend;
        int bad_pin;
        int bad_done;
        logic [3:0] ap, ep;
        logic ad, ed;
        e_hex = hx; e_idle = idl; e_len = ln; e_step = st; e_wait = wt; e_gap = gp; e_reps = rp;
        tend = end_time();
        bad_pin = 0; bad_done = 0;
        ap = '0; ep = '0; ad = 1'b0; ed = 1'b0;
        @(negedge clk);
        cfg_hex = hx; cfg_idle = idl; cfg_len = AW'(ln); cfg_step = CW'(st);
        cfg_wait = CW'(wt); cfg_gap = CW'(gp); cfg_reps = RW'(rp);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int t = 0; t <= tend + 2; t++) begin
            if (bad_pin == 0 && pins !== exp_pins(t)) begin
                bad_pin = 1; ap = pins; ep = exp_pins(t);
            end
            if (bad_done == 0 && done !== (t == tend)) begin
                bad_done = 1; ad = done; ed = (t == tend);
            end
            start = poke_start && (t == 2);
            if (poke_cfg && t == 1) begin
                cfg_hex = ~hx; cfg_len = AW'($urandom); cfg_step = CW'($urandom % 3);
                cfg_wait = CW'($urandom % 4); cfg_gap = CW'($urandom % 4); cfg_reps = RW'($urandom % 3);
            end
            @(negedge clk);
        end
        start = 1'b0;
        check({tag, " pins"}, bad_pin ? {4'h0, ap} : 8'h0, bad_pin ? {4'h0, ep} : 8'h0);
        check({tag, " done"}, bad_done ? {7'h0, ad} : 8'h0, bad_done ? {7'h0, ed} : 8'h1 & 8'h0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state with idle high, then low
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pins idle high", {4'h0, pins}, 8'h0F);
        check("R1 done low", {7'h0, done}, 8'h00);
        cfg_idle = 1'b0;
        #1;
        check("R1 pins idle low", {4'h0, pins}, 8'h00);

        load_pattern(1'b0);  // R10: known pattern i^5
        // R4 R3 R2: single pin, zero offset, one-cycle steps
        run_case("R4 R3 single-pin", 1'b0, 1'b0, 7, 0, 0, 0, 0, 1'b0, 1'b0);
        // R5 R3 R6: hex, full depth, back-to-back plays with offset
        run_case("R5 R6 hex full-depth no-gap", 1'b1, 1'b0, 15, 2, 3, 0, 2, 1'b0, 1'b0);
        // R6 R7: one element, gaps, idle high
        run_case("R6 R7 hex gap idle-high", 1'b1, 1'b1, 0, 1, 0, 3, 1, 1'b0, 1'b0);
        // R2: long offset in single-pin mode with idle high
        run_case("R2 offset single-pin", 1'b0, 1'b1, 3, 1, 9, 2, 1, 1'b0, 1'b0);
        // R8: start pulse mid sequence ignored
        run_case("R8 start ignored", 1'b1, 1'b0, 5, 1, 1, 2, 1, 1'b1, 1'b0);
        // R9: settings changed mid sequence ignored
        run_case("R9 cfg captured", 1'b0, 1'b0, 6, 1, 2, 1, 2, 1'b0, 1'b1);

        load_pattern(1'b1);  // R10: random pattern
        for (int k = 0; k < 30; k++) begin
            run_case("R3 R6 random", 1'($urandom), 1'($urandom), int'($urandom % 16),
                     int'($urandom % 4), int'($urandom % 6), int'($urandom % 5),
                     int'($urandom % 4), 1'b0, 1'b0);
            if (k % 10 == 9) load_pattern(1'b1);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule